// File: doc/BRIEF.md
# Dual-Memory Two-Phase Execute Sequencer

This block sequences a small processor core that can run code out of either of two dual-ported memories: a register RAM, which also holds the operands, and a lookup RAM. Both memories sit outside the block. The block drives their ports and receives their read data, which returns one clock after the address. An ordinary instruction takes a two-clock beat. In the first clock the operands arrive, the ALU result is formed and the next fetch is issued. In the second clock the fetched word is decoded and its operands are read. Each result is written to the register RAM in the first clock of the following beat. A forwarding path delivers that result to the next instruction without an extra clock.

Four operations are provided: move, add, a lookup read that loads a register from the lookup RAM, and a lookup write that stores a register into the lookup RAM. A mode instruction selects which memory supplies instructions. A lookup read cannot present its address before its first execution clock, because that address may be the forwarded result of the instruction just before it. Its data is latched into a holding register one clock later. That value then goes through the result multiplexer like any other result, so a lookup read costs three clocks. The second port of the lookup RAM belongs to another agent, so the block has no connection to it. A debug port shows the next fetch address and the holding register.

Top module: `dual_mem_sequencer`

## Requirements
- R1: While reset is held and in the first clock after it, `dbg_pc` is 0, `mode_lut` is 0 and no register write is driven. The first fetch reads register-RAM address 0 in the first clock after reset.
- R2: Move, add, mode and no-operation instructions take two clocks. A fetch is issued every second clock, and each move or add result is written on register port B in the clock two cycles after the next fetch.
- R3: In register execute mode, register port A carries the fetch (address = `dbg_pc`) in the fetch clock. In the following clock it carries the source read (S field), while port B carries the destination read (D field).
- R4: In lookup execute mode, the fetch is made on lookup port A (read, address = `dbg_pc`), and register port A is idle in fetch clocks.
- R5: A lookup read (op 2) takes three clocks. Lookup port A reads at address = low bits of the source value, two clocks after its fetch. `dbg_hold` shows that data four clocks after the fetch, and the next fetch is three clocks after its own.
- R6: The lookup read result is written to the D register through the normal write path, and it is forwarded to the next instruction.
- R7: A lookup write (op 3) in register execute mode stores the D register value at lookup address = source value two clocks after its fetch, and it takes two clocks.
- R8: A lookup write in lookup execute mode issues no fetch in its write clock. The next fetch follows one clock later, so the instruction takes three clocks.
- R9: A move or add whose S or D field names the register written by the previous instruction uses that previous result, with no added clock.
- R10: A mode instruction (op 4) selects lookup execution when S bit 0 is 1 and register execution when it is 0. The selection applies from the very next fetch.
- R11: The instruction word is laid out as follows: op in bits [31:28], D in bits [17:9], S in bits [8:0], bits [27:18] reserved. Op codes are 0 move (D=S), 1 add (D=D+S), 2 lookup read, 3 lookup write and 4 mode. Any other op, or any non-zero reserved bit, makes the word a no-operation that writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rg_a_en | output | 1 | Register RAM port A read enable |
| rg_a_addr | output | AW | Register RAM port A address |
| rg_a_rdata | input | DW | Register RAM port A read data (one clock after address) |
| rg_b_en | output | 1 | Register RAM port B enable |
| rg_b_we | output | 1 | Register RAM port B write enable |
| rg_b_addr | output | AW | Register RAM port B address |
| rg_b_wdata | output | DW | Register RAM port B write data |
| rg_b_rdata | input | DW | Register RAM port B read data |
| lt_a_en | output | 1 | Lookup RAM port A enable |
| lt_a_we | output | 1 | Lookup RAM port A write enable |
| lt_a_addr | output | AW | Lookup RAM port A address |
| lt_a_wdata | output | DW | Lookup RAM port A write data |
| lt_a_rdata | input | DW | Lookup RAM port A read data |
| mode_lut | output | 1 | Current execute mode, 1 = lookup RAM |
| fwd_valid | output | 1 | Forwarded result pending write |
| fwd_addr | output | AW | Destination of the forwarded result |
| fwd_data | output | DW | Forwarded result value |
| dbg_pc | output | AW | Next fetch address |
| dbg_hold | output | DW | Lookup read holding register |

## Verification
Timing is measured from the fetch clock f of each instruction. The operand reads are due at f+1 and the lookup access at f+2. The holding register shows the lookup data at f+4. The register write lands two clocks after the next instruction's fetch, which is f+4 for a two-clock instruction and f+5 after a lookup read. An instruction-level model in the bench runs the program, derives the fetch cycle of every instruction from the 2- and 3-clock costs, and files each expected port event under its exact cycle number. Every clock, sampled on the falling edge, the ports are compared with that cycle's entry: an event that is missing, or one that appears in a cycle with no entry, are both counted as failures.

// File: rtl/dual_mem_sequencer.sv
module dual_mem_sequencer #(
  parameter int DW  = 32,
  parameter int AW  = 9,
  parameter int OPW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          rg_a_en,
  output logic [AW-1:0] rg_a_addr,
  input  logic [DW-1:0] rg_a_rdata,
  output logic          rg_b_en,
  output logic          rg_b_we,
  output logic [AW-1:0] rg_b_addr,
  output logic [DW-1:0] rg_b_wdata,
  input  logic [DW-1:0] rg_b_rdata,
  output logic          lt_a_en,
  output logic          lt_a_we,
  output logic [AW-1:0] lt_a_addr,
  output logic [DW-1:0] lt_a_wdata,
  input  logic [DW-1:0] lt_a_rdata,
  output logic          mode_lut,
  output logic          fwd_valid,
  output logic [AW-1:0] fwd_addr,
  output logic [DW-1:0] fwd_data,
  output logic [AW-1:0] dbg_pc,
  output logic [DW-1:0] dbg_hold
);
  localparam int RSV_HI = DW - OPW - 1;
  localparam int RSV_LO = 2 * AW;
  localparam logic [OPW-1:0] OP_MOV  = OPW'(0);
  localparam logic [OPW-1:0] OP_ADD  = OPW'(1);
  localparam logic [OPW-1:0] OP_RDL  = OPW'(2);
  localparam logic [OPW-1:0] OP_WRL  = OPW'(3);
  localparam logic [OPW-1:0] OP_MODE = OPW'(4);

  typedef enum logic [1:0] {ST_G, ST_S, ST_X} phase_t;

  phase_t          st;
  logic [AW-1:0]   pc;
  logic [OPW-1:0]  ir_op;
  logic [AW-1:0]   ir_d, ir_s;
  logic            iv;
  logic [DW-1:0]   res_q, hold;
  logic [AW-1:0]   wb_a;
  logic            wb_v, rd_pend;

  logic [DW-1:0]   fword, src_v, dst_v, res_d;
  logic            f_ok;
  logic            is_mov, is_add, is_rdl, is_wrl, is_mode;
  logic            g_stall, nmode, fetch_now, fetch_lut, fetch_rg;

  assign fword = mode_lut ? lt_a_rdata : rg_a_rdata;
  assign f_ok  = (fword[RSV_HI:RSV_LO] == '0);

  assign is_mov  = iv && ir_op == OP_MOV;
  assign is_add  = iv && ir_op == OP_ADD;
  assign is_rdl  = iv && ir_op == OP_RDL;
  assign is_wrl  = iv && ir_op == OP_WRL;
  assign is_mode = iv && ir_op == OP_MODE;

  assign src_v = (wb_v && wb_a == ir_s) ? res_q : rg_a_rdata;
  assign dst_v = (wb_v && wb_a == ir_d) ? res_q : rg_b_rdata;

  assign res_d = (st == ST_X) ? hold : (is_add ? dst_v + src_v : src_v);

  assign g_stall   = is_rdl || (is_wrl && mode_lut);
  assign nmode     = is_mode ? ir_s[0] : mode_lut;
  assign fetch_now = (st == ST_G && !g_stall) || st == ST_S;
  assign fetch_lut = fetch_now && ((st == ST_G) ? nmode : mode_lut);
  assign fetch_rg  = fetch_now && !fetch_lut;

  assign rg_a_en   = fetch_rg || st == ST_X;
  assign rg_a_addr = (st == ST_X) ? fword[AW-1:0] : pc;

  assign rg_b_en    = (st == ST_G && wb_v) || st == ST_X;
  assign rg_b_we    = st == ST_G && wb_v;
  assign rg_b_addr  = (st == ST_X) ? fword[2*AW-1:AW] : wb_a;
  assign rg_b_wdata = res_q;

  assign lt_a_en    = fetch_lut || (st == ST_G && (is_rdl || is_wrl));
  assign lt_a_we    = st == ST_G && is_wrl;
  assign lt_a_addr  = fetch_lut ? pc : src_v[AW-1:0];
  assign lt_a_wdata = dst_v;

  assign fwd_valid = wb_v;
  assign fwd_addr  = wb_a;
  assign fwd_data  = res_q;
  assign dbg_pc    = pc;
  assign dbg_hold  = hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_G;
      pc       <= '0;
      mode_lut <= 1'b0;
      iv       <= 1'b0;
      ir_op    <= '0;
      ir_d     <= '0;
      ir_s     <= '0;
      res_q    <= '0;
      wb_a     <= '0;
      wb_v     <= 1'b0;
      hold     <= '0;
      rd_pend  <= 1'b0;
    end else begin
      if (fetch_now) pc <= pc + AW'(1);
      unique case (st)
        ST_G: begin
          mode_lut <= nmode;
          rd_pend  <= is_rdl;
          if (is_mov || is_add) begin
            res_q <= res_d;
            wb_a  <= ir_d;
            wb_v  <= 1'b1;
          end else begin
            wb_v  <= 1'b0;
          end
          st <= g_stall ? ST_S : ST_X;
        end
        ST_S: begin
          if (rd_pend) hold <= lt_a_rdata;
          st <= ST_X;
        end
        default: begin
          iv    <= 1'b1;
          ir_op <= f_ok ? fword[DW-1 -: OPW] : {OPW{1'b1}};
          ir_d  <= fword[2*AW-1:AW];
          ir_s  <= fword[AW-1:0];
          if (rd_pend) begin
            res_q   <= res_d;
            wb_a    <= ir_d;
            wb_v    <= 1'b1;
            rd_pend <= 1'b0;
          end
          st <= ST_G;
        end
      endcase
    end
  end

  p_write_after_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rg_b_we |-> $past(st == ST_X));

  p_pc_steps_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_X) |-> pc == $past(pc) + AW'(1));

  p_decode_follows_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_X) |-> $past(rg_a_en || lt_a_en));

  p_lut_mode_no_reg_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_lut && st == ST_S) |-> !rg_a_en);

  p_hold_from_lut_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_X && rd_pend) |-> $past(lt_a_en && !lt_a_we, 2));

  p_wrl_lut_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_G && lt_a_en && lt_a_we && mode_lut) |=> (st == ST_S && !rg_b_we));
endmodule

// File: tb/dual_mem_sequencer_tb.sv
`timescale 1ns/1ps
module dual_mem_sequencer_tb;
  localparam int DW = 32;
  localparam int AW = 9;
  localparam int DEPTH = 1 << AW;
  localparam int N = 28;
  localparam logic [31:0] NOPW = 32'hF000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          rg_a_en, rg_b_en, rg_b_we, lt_a_en, lt_a_we;
  logic [AW-1:0] rg_a_addr, rg_b_addr, lt_a_addr, fwd_addr, dbg_pc;
  logic [DW-1:0] rg_a_rdata, rg_b_rdata, lt_a_rdata, rg_b_wdata, lt_a_wdata;
  logic [DW-1:0] fwd_data, dbg_hold;
  logic          mode_lut, fwd_valid;

  dual_mem_sequencer #(.DW(DW), .AW(AW), .OPW(4)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rg_a_en(rg_a_en), .rg_a_addr(rg_a_addr), .rg_a_rdata(rg_a_rdata),
    .rg_b_en(rg_b_en), .rg_b_we(rg_b_we), .rg_b_addr(rg_b_addr),
    .rg_b_wdata(rg_b_wdata), .rg_b_rdata(rg_b_rdata),
    .lt_a_en(lt_a_en), .lt_a_we(lt_a_we), .lt_a_addr(lt_a_addr),
    .lt_a_wdata(lt_a_wdata), .lt_a_rdata(lt_a_rdata),
    .mode_lut(mode_lut), .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
    .fwd_data(fwd_data), .dbg_pc(dbg_pc), .dbg_hold(dbg_hold)
  );

  logic [DW-1:0] rg_mem [DEPTH];
  logic [DW-1:0] lt_mem [DEPTH];

  always @(posedge clk) begin
    if (rg_a_en) rg_a_rdata <= rg_mem[rg_a_addr];
    if (rg_b_en) begin
      if (rg_b_we) rg_mem[rg_b_addr] <= rg_b_wdata;
      else rg_b_rdata <= rg_mem[rg_b_addr];
    end
    if (lt_a_en) begin
      if (lt_a_we) lt_mem[lt_a_addr] <= lt_a_wdata;
      else lt_a_rdata <= lt_mem[lt_a_addr];
    end
  end

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ins(input int op, input int d, input int s);
    return {4'(op), 10'b0, 9'(d), 9'(s)};
  endfunction

  logic [DW-1:0] iss_reg [DEPTH];
  logic [DW-1:0] iss_lut [DEPTH];

  bit          ef_mode [int];
  int          ef_pc [int];
  bit          e_after_mode [int];
  int          ex_s [int];
  int          ex_d [int];
  int          ew_addr [int];
  logic [31:0] ew_data [int];
  int          elw_addr [int];
  logic [31:0] elw_data [int];
  int          elr_addr [int];
  logic [31:0] eh [int];

  int horizon;

  task automatic run_model();
    int t = 0;
    int pc = 0;
    bit md = 1'b0;
    bit prev_mode = 1'b0;
    for (int i = 0; i < N; i++) begin
      logic [31:0] w;
      int op, d, s, a, cost;
      logic [31:0] v;
      w = md ? iss_lut[pc] : iss_reg[pc];
      ef_mode[t] = md;
      ef_pc[t] = pc;
      if (prev_mode) e_after_mode[t] = 1'b1;
      ex_s[t+1] = int'(w[8:0]);
      ex_d[t+1] = int'(w[17:9]);
      pc = (pc + 1) % DEPTH;
      op = int'(w[31:28]);
      if (w[27:18] != 10'd0) op = 15;
      d = int'(w[17:9]);
      s = int'(w[8:0]);
      cost = 2;
      prev_mode = 1'b0;
      case (op)
        0, 1: begin
          v = (op == 1) ? iss_reg[d] + iss_reg[s] : iss_reg[s];
          iss_reg[d] = v;
          ew_addr[t+4] = d;
          ew_data[t+4] = v;
        end
        2: begin
          a = int'(iss_reg[s][AW-1:0]);
          v = iss_lut[a];
          elr_addr[t+2] = a;
          eh[t+4] = v;
          iss_reg[d] = v;
          ew_addr[t+5] = d;
          ew_data[t+5] = v;
          cost = 3;
        end
        3: begin
          a = int'(iss_reg[s][AW-1:0]);
          iss_lut[a] = iss_reg[d];
          elw_addr[t+2] = a;
          elw_data[t+2] = iss_reg[d];
          if (md) cost = 3;
        end
        4: begin
          md = w[0];
          prev_mode = 1'b1;
        end
        default: ;
      endcase
      t += cost;
    end
    horizon = t;
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      rg_mem[a] = (a >= 200 && a < 256) ? 32'd0 : NOPW;
      lt_mem[a] = NOPW;
    end
    rg_mem[200] = 32'd5;
    rg_mem[201] = 32'd7;
    rg_mem[202] = 32'd400;
    rg_mem[203] = 32'h0000_AAAA;
    rg_mem[204] = 32'd401;
    lt_mem[400] = 32'h0000_1234;
    lt_mem[401] = 32'h0000_0055;
    rg_mem[0]  = ins(1, 201, 200);
    rg_mem[1]  = ins(1, 205, 201);
    rg_mem[2]  = ins(1, 201, 201);
    rg_mem[3]  = ins(2, 206, 202);
    rg_mem[4]  = ins(1, 206, 206);
    rg_mem[5]  = ins(3, 203, 204);
    rg_mem[6]  = ins(2, 207, 204);
    rg_mem[7]  = ins(0, 208, 207);
    rg_mem[8]  = ins(0, 210, 202);
    rg_mem[9]  = ins(2, 211, 210);
    rg_mem[10] = ins(4, 0, 1);
    lt_mem[11] = ins(1, 212, 200);
    lt_mem[12] = ins(2, 213, 202);
    lt_mem[13] = ins(3, 200, 204);
    lt_mem[14] = ins(2, 214, 204);
    lt_mem[15] = ins(0, 215, 214);
    lt_mem[16] = ins(4, 0, 0);
    rg_mem[17] = ins(1, 216, 215);
    rg_mem[18] = ins(2, 217, 202);
    rg_mem[19] = ins(2, 218, 204);
    rg_mem[20] = ins(5, 220, 200);
    rg_mem[21] = ins(0, 221, 200) | 32'h0010_0000;
    for (int a = 0; a < DEPTH; a++) begin
      iss_reg[a] = rg_mem[a];
      iss_lut[a] = lt_mem[a];
    end
    run_model();

    repeat (3) @(negedge clk);
    chk(dbg_pc == '0, "R1 pc in reset", 32'(dbg_pc), 32'd0);
    chk(!mode_lut, "R1 mode in reset", 32'(mode_lut), 32'd0);
    chk(!rg_b_we && !fwd_valid, "R1 no write in reset", 32'(rg_b_we), 32'd0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    for (int c = 0; c < horizon; c++) begin
      bit obs_f, exp_f, obs_w, obs_lw;
      @(negedge clk);
      if (c == 0) chk(dbg_pc == '0 && !mode_lut, "R1 first cycle state", 32'(dbg_pc), 32'd0);
      obs_f = (rg_a_en && !ex_s.exists(c)) || (lt_a_en && !lt_a_we && !elr_addr.exists(c));
      exp_f = ef_pc.exists(c);
      chk(obs_f == exp_f, $sformatf("R2 R5 R8 fetch timing cycle %0d", c), 32'(obs_f), 32'(exp_f));
      if (exp_f) begin
        if (ef_mode[c])
          chk(lt_a_en && !lt_a_we && !rg_a_en && lt_a_addr == AW'(ef_pc[c]),
              "R4 lookup fetch port", 32'(lt_a_addr), 32'(ef_pc[c]));
        else
          chk(rg_a_en && rg_a_addr == AW'(ef_pc[c]), "R3 register fetch port",
              32'(rg_a_addr), 32'(ef_pc[c]));
        if (e_after_mode.exists(c))
          chk((lt_a_en && !lt_a_we) == ef_mode[c], "R10 mode applies to next fetch",
              32'(lt_a_en), 32'(ef_mode[c]));
      end
      if (ex_s.exists(c))
        chk(rg_a_en && rg_a_addr == AW'(ex_s[c]) && rg_b_en && !rg_b_we && rg_b_addr == AW'(ex_d[c]),
            "R3 R4 operand reads", {7'd0, rg_a_addr, 7'd0, rg_b_addr},
            {7'd0, 9'(ex_s[c]), 7'd0, 9'(ex_d[c])});
      obs_w = rg_b_en && rg_b_we;
      chk(obs_w == ew_addr.exists(c), $sformatf("R2 R11 register write presence cycle %0d", c),
          32'(obs_w), 32'(ew_addr.exists(c)));
      if (obs_w && ew_addr.exists(c))
        chk(rg_b_addr == AW'(ew_addr[c]) && rg_b_wdata == ew_data[c] && fwd_data == ew_data[c],
            "R6 R9 register write value", rg_b_wdata, ew_data[c]);
      obs_lw = lt_a_en && lt_a_we;
      chk(obs_lw == elw_addr.exists(c), "R7 R8 lookup write presence",
          32'(obs_lw), 32'(elw_addr.exists(c)));
      if (obs_lw && elw_addr.exists(c))
        chk(lt_a_addr == AW'(elw_addr[c]) && lt_a_wdata == elw_data[c],
            "R7 lookup write value", lt_a_wdata, elw_data[c]);
      if (elr_addr.exists(c))
        chk(lt_a_en && !lt_a_we && lt_a_addr == AW'(elr_addr[c]), "R5 lookup read issue",
            32'(lt_a_addr), 32'(elr_addr[c]));
      if (eh.exists(c))
        chk(dbg_hold == eh[c], "R5 holding register", dbg_hold, eh[c]);
    end

    repeat (2) @(negedge clk);
    begin
      int bad_r = 0;
      int bad_l = 0;
      for (int a = 0; a < DEPTH; a++) begin
        if (rg_mem[a] !== iss_reg[a]) bad_r++;
        if (lt_mem[a] !== iss_lut[a]) bad_l++;
      end
      chk(bad_r == 0, "R6 R9 final register contents", 32'(bad_r), 32'd0);
      chk(bad_l == 0, "R7 R8 final lookup contents", 32'(bad_l), 32'd0);
      chk(iss_reg[211] == 32'h1234 && iss_reg[214] == 32'd5, "R6 model sanity",
          iss_reg[211], 32'h1234);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule